// File: doc/BRIEF.md
# Flash Read Cache

This block sits between a processor read port and the port that fetches 128-bit lines from serial flash. Reads inside the cacheable window are looked up in 8 KB of line storage, organised as 512 lines of 16 bytes. On a miss, the block asks the fetch port for the whole line, stores it, and then returns the requested 32-bit word. Reads through the alias window, reads to addresses outside both windows, and every read while the disable input is high go straight to the fetch port and leave the storage untouched.

The storage runs in one of two arrangements, chosen by a mode input. The first is four ways of 128 sets each. Each way of a set keeps a small use counter, and on a miss the way with the lowest count is replaced. The second is a direct-mapped array of 512 lines. Changing the mode throws away every line. Two profiling counters count cache-mode hits and misses. They can be frozen, and they stop at full scale rather than wrapping.

Top module: `flash_read_cache`

## Requirements
- R1: After reset `reqReady` is 1, `respValid` and `fillReq` are 0, and both profiling counters read 0.
- R2: A cacheable read (0x0200000 to 0x11FFFFF, flash offset = address − 0x0200000) that misses raises `fillReq` with `fillAddr` = offset with bits [3:0] cleared, and holds it until `fillValid`. The response carries `fillData[32*k +: 32]` with k = offset[3:2], and `respValid` pulses on the edge after the `fillValid` edge.
- R3: A cacheable read whose line is present causes no fill request. `respValid` pulses for one cycle on the second rising edge after the request is accepted.
- R4: Reads in the alias window (0x1200000 to 0x21FFFFF, offset = address − 0x1200000) are always fetched and never allocate or update a line. So are reads outside both windows, which use address bits [23:0] as the offset.
- R5: While `cacheDisable` is 1, every read is fetched and no line is added or changed. Lines cached earlier hit again once it returns to 0.
- R6: In 4-way mode (`directMapEn` = 0), set = offset[10:4] and tag = offset[23:11], and four lines with the same set and different tags are all held at once.
- R7: In 4-way mode, filling a way sets its use count to 1. Each hit adds 1, saturating at 2^HIT_W − 1. A miss replaces the way with the lowest count, and an invalid way counts as 0.
- R8: When several ways share the lowest count, the highest-numbered way is replaced. Empty ways therefore fill in the order 3, 2, 1, 0.
- R9: In direct-mapped mode (`directMapEn` = 1), index = offset[12:4] and tag = offset[23:13]. Two lines with the same index evict each other, and lines with different indexes coexist.
- R10: A change of `directMapEn` drops `reqReady` and invalidates every line before the next request is accepted.
- R11: `hitCount` and `missCount` count cache-mode hits and misses while `profStop` is 0 and hold while it is 1. Bypassed reads are never counted.
- R12: Each profiling counter stops at 2^CNT_W − 1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cacheDisable | input | 1 | 1 forces every read to bypass |
| directMapEn | input | 1 | 1 selects direct-mapped, 0 selects 4-way |
| profStop | input | 1 | 1 freezes the profiling counters |
| reqValid | input | 1 | Read request |
| reqAddr | input | CPU_AW | Byte address of the read |
| reqReady | output | 1 | Request accepted on this edge when high with reqValid |
| respValid | output | 1 | One-cycle pulse with the read word |
| respData | output | 32 | Read word |
| fillReq | output | 1 | Line fetch request, held until fillValid |
| fillAddr | output | FLASH_AW | Line-aligned flash offset |
| fillValid | input | 1 | Fetched line is present |
| fillData | input | 128 | Fetched line, word k in bits [32k+31:32k] |
| hitCount | output | CNT_W | Saturating hit counter |
| missCount | output | CNT_W | Saturating miss counter |

## Verification
The bench drives repeated reads to one line, which separates a first miss from later hits through the fill count and the response latency. It also reads the same word through the cacheable window, the alias window and the disabled path after the flash contents have changed, which shows stale cached data against fresh bypass data. Groups of five tags aimed at one set test replacement. With equal use counts they expose the tie order. With one way hit less often they expose lowest-count choice. With one way hit past the counter width they expose saturation against wrap. Pairs of addresses that differ only in offset bits 11 and 13, read under each mode, tell 9-bit direct indexing from 7-bit set indexing and show the invalidation on a mode change.

// File: rtl/flash_cache_pkg.sv
package flash_cache_pkg;

  // Strobes from the control FSM to the datapath, all single cycle.
  typedef struct packed {
    logic latchReq;    // capture request address
    logic hitUpdate;   // bump use count, answer from storage
    logic fillAlloc;   // write fetched line, answer from line
    logic fillPass;    // answer from fetched line, no write
    logic countHit;    // profiling hit event
    logic countMiss;   // profiling miss event
    logic flushClear;  // invalidate one set in all ways
  } strobe_t;

endpackage

// File: rtl/flash_cache_ctrl.sv
module flash_cache_ctrl
  import flash_cache_pkg::*;
#(
  parameter int SET_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             directMapEn,
  input  logic             fillValid,
  input  logic             isHit,
  input  logic             isBypass,
  output logic             reqReady,
  output logic             fillReq,
  output logic             modeDm,
  output logic [SET_W-1:0] flushIdx,
  output strobe_t          stb
);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_FETCH, S_FLUSH} state_t;

  localparam logic [SET_W-1:0] LAST_SET = '1;

  state_t           state, stateNext;
  logic             modeQ, bypassQ;
  logic [SET_W-1:0] flushCnt;
  logic             modePending;

  assign modePending = directMapEn != modeQ;
  assign reqReady    = (state == S_IDLE) && !modePending;
  assign fillReq     = (state == S_FETCH);
  assign modeDm      = modeQ;
  assign flushIdx    = flushCnt;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (modePending) begin
          stateNext = S_FLUSH;
        end else if (reqValid) begin
          stb.latchReq = 1'b1;
          stateNext    = S_CHECK;
        end
      end
      S_CHECK: begin
        stb.hitUpdate = !isBypass && isHit;
        stb.countHit  = !isBypass && isHit;
        stb.countMiss = !isBypass && !isHit;
        stateNext     = (!isBypass && isHit) ? S_IDLE : S_FETCH;
      end
      S_FETCH: begin
        if (fillValid) begin
          stb.fillAlloc = !bypassQ;
          stb.fillPass  = bypassQ;
          stateNext     = S_IDLE;
        end
      end
      S_FLUSH: begin
        stb.flushClear = 1'b1;
        if (flushCnt == LAST_SET) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      modeQ    <= 1'b0;
      bypassQ  <= 1'b0;
      flushCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && modePending) begin
        modeQ    <= directMapEn;
        flushCnt <= '0;
      end
      if (state == S_FLUSH) flushCnt <= flushCnt + 1'b1;
      if (state == S_CHECK) bypassQ <= isBypass;
    end
  end

endmodule

// File: rtl/flash_cache_dp.sv
module flash_cache_dp
  import flash_cache_pkg::*;
#(
  parameter int                CPU_AW     = 26,
  parameter int                FLASH_AW   = 24,
  parameter int                LINE_BYTES = 16,
  parameter int                WAYS       = 4,
  parameter int                SETS       = 128,
  parameter int                HIT_W      = 4,
  parameter int                CNT_W      = 32,
  parameter logic [CPU_AW-1:0] CACHE_BASE = 26'h0200000,
  parameter logic [CPU_AW-1:0] ALIAS_BASE = 26'h1200000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [$clog2(SETS)-1:0]   flushIdx,
  input  logic                      modeDm,
  input  logic                      cacheDisable,
  input  logic                      profStop,
  input  logic [CPU_AW-1:0]         reqAddr,
  input  logic [LINE_BYTES*8-1:0]   fillData,
  output logic                      isHit,
  output logic                      isBypass,
  output logic [FLASH_AW-1:0]       fillAddr,
  output logic                      respValid,
  output logic [31:0]               respData,
  output logic [CNT_W-1:0]          hitCount,
  output logic [CNT_W-1:0]          missCount
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = FLASH_AW - OFF_W - SET_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int SEL_W  = OFF_W - 2;

  logic              valid   [WAYS][SETS];
  logic [HIT_W-1:0]  useCnt  [WAYS][SETS];
  logic [TAG_W-1:0]  tagMem  [WAYS][SETS];
  logic [LINE_W-1:0] dataMem [WAYS][SETS];

  logic [CPU_AW-1:0]   reqAddrQ, diffC, diffA;
  logic                inCache, inAlias;
  logic [FLASH_AW-1:0] offset;
  logic [SET_W-1:0]    setIdx;
  logic [TAG_W-1:0]    tagIn;
  logic [WAY_W-1:0]    dmWay, hitWay, lfuWay, victim;
  logic [SEL_W-1:0]    wordSel;
  logic [31:0]         hitWord, fillWord;

  // Window decode: an in-window address leaves no bits above the flash width.
  assign diffC   = reqAddrQ - CACHE_BASE;
  assign diffA   = reqAddrQ - ALIAS_BASE;
  assign inCache = diffC[CPU_AW-1:FLASH_AW] == '0;
  assign inAlias = diffA[CPU_AW-1:FLASH_AW] == '0;
  assign offset  = inCache ? diffC[FLASH_AW-1:0] :
                   inAlias ? diffA[FLASH_AW-1:0] : reqAddrQ[FLASH_AW-1:0];

  assign setIdx   = offset[OFF_W +: SET_W];
  assign tagIn    = offset[FLASH_AW-1 -: TAG_W];
  assign dmWay    = offset[OFF_W+SET_W +: WAY_W];
  assign wordSel  = offset[2 +: SEL_W];
  assign isBypass = cacheDisable || !inCache;
  assign fillAddr = {offset[FLASH_AW-1:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    isHit  = 1'b0;
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid[w][setIdx] && tagMem[w][setIdx] == tagIn &&
          (!modeDm || WAY_W'(w) == dmWay)) begin
        isHit  = 1'b1;
        hitWay = WAY_W'(w);
      end
    end
  end

  // Lowest use count; "<=" lets a later (higher) way win a tie.
  always_comb begin
    lfuWay = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (useCnt[w][setIdx] <= useCnt[lfuWay][setIdx]) lfuWay = WAY_W'(w);
    end
    victim = modeDm ? dmWay : lfuWay;
  end

  assign hitWord  = dataMem[hitWay][setIdx][{wordSel, 5'b0} +: 32];
  assign fillWord = fillData[{wordSel, 5'b0} +: 32];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqAddrQ <= '0;
    else if (stb.latchReq) reqAddrQ <= reqAddr;
  end

  always_ff @(posedge clk) begin
    if (stb.fillAlloc) begin
      tagMem[victim][setIdx]  <= tagIn;
      dataMem[victim][setIdx] <= fillData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) begin
        for (int s = 0; s < SETS; s++) begin
          valid[w][s]  <= 1'b0;
          useCnt[w][s] <= '0;
        end
      end
      respValid <= 1'b0;
      respData  <= '0;
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      respValid <= 1'b0;
      if (stb.flushClear) begin
        for (int w = 0; w < WAYS; w++) begin
          valid[w][flushIdx]  <= 1'b0;
          useCnt[w][flushIdx] <= '0;
        end
      end
      if (stb.hitUpdate) begin
        if (useCnt[hitWay][setIdx] != '1)
          useCnt[hitWay][setIdx] <= useCnt[hitWay][setIdx] + 1'b1;
        respValid <= 1'b1;
        respData  <= hitWord;
      end
      if (stb.fillAlloc) begin
        valid[victim][setIdx]  <= 1'b1;
        useCnt[victim][setIdx] <= HIT_W'(1);
      end
      if (stb.fillAlloc || stb.fillPass) begin
        respValid <= 1'b1;
        respData  <= fillWord;
      end
      if (stb.countHit && !profStop && hitCount != '1)
        hitCount <= hitCount + 1'b1;
      if (stb.countMiss && !profStop && missCount != '1)
        missCount <= missCount + 1'b1;
    end
  end

endmodule

// File: rtl/flash_read_cache.sv
module flash_read_cache
  import flash_cache_pkg::*;
#(
  parameter int                CPU_AW     = 26,
  parameter int                FLASH_AW   = 24,
  parameter int                LINE_BYTES = 16,
  parameter int                WAYS       = 4,
  parameter int                SETS       = 128,
  parameter int                HIT_W      = 4,
  parameter int                CNT_W      = 32,
  parameter logic [CPU_AW-1:0] CACHE_BASE = 26'h0200000,
  parameter logic [CPU_AW-1:0] ALIAS_BASE = 26'h1200000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cacheDisable,
  input  logic                    directMapEn,
  input  logic                    profStop,
  input  logic                    reqValid,
  input  logic [CPU_AW-1:0]       reqAddr,
  output logic                    reqReady,
  output logic                    respValid,
  output logic [31:0]             respData,
  output logic                    fillReq,
  output logic [FLASH_AW-1:0]     fillAddr,
  input  logic                    fillValid,
  input  logic [LINE_BYTES*8-1:0] fillData,
  output logic [CNT_W-1:0]        hitCount,
  output logic [CNT_W-1:0]        missCount
);

  localparam int SET_W = $clog2(SETS);

  strobe_t          stb;
  logic             isHit, isBypass, modeDm;
  logic [SET_W-1:0] flushIdx;

  flash_cache_ctrl #(.SET_W(SET_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .directMapEn(directMapEn),
    .fillValid(fillValid), .isHit(isHit), .isBypass(isBypass),
    .reqReady(reqReady), .fillReq(fillReq), .modeDm(modeDm),
    .flushIdx(flushIdx), .stb(stb)
  );

  flash_cache_dp #(
    .CPU_AW(CPU_AW), .FLASH_AW(FLASH_AW), .LINE_BYTES(LINE_BYTES),
    .WAYS(WAYS), .SETS(SETS), .HIT_W(HIT_W), .CNT_W(CNT_W),
    .CACHE_BASE(CACHE_BASE), .ALIAS_BASE(ALIAS_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .flushIdx(flushIdx), .modeDm(modeDm),
    .cacheDisable(cacheDisable), .profStop(profStop), .reqAddr(reqAddr),
    .fillData(fillData), .isHit(isHit), .isBypass(isBypass),
    .fillAddr(fillAddr), .respValid(respValid), .respData(respData),
    .hitCount(hitCount), .missCount(missCount)
  );

endmodule

// File: rtl/flash_read_cache_chk.sv
module flash_read_cache_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             respValid,
  input logic             fillReq,
  input logic             fillValid,
  input logic             profStop,
  input logic [CNT_W-1:0] hitCount,
  input logic [CNT_W-1:0] missCount
);

  assert_fill_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    fillReq && !fillValid |=> fillReq);

  assert_resp_idle_fetch_R2: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !fillReq);

  assert_resp_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  assert_prof_freeze_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(profStop) |-> $stable(hitCount) && $stable(missCount));

  assert_no_wrap_R12: assert property (@(posedge clk) disable iff (!rstN)
    hitCount >= $past(hitCount) && missCount >= $past(missCount));

endmodule

bind flash_read_cache flash_read_cache_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .respValid(respValid), .fillReq(fillReq), .fillValid(fillValid),
  .profStop(profStop), .hitCount(hitCount), .missCount(missCount)
);

// File: tb/test_flash_read_cache.sv
`timescale 1ns/1ps
module test_flash_read_cache;

  localparam int CNT_W = 4;
  localparam int HIT_W = 2;

  logic         clk = 1'b0, rstN = 1'b0;
  logic         cacheDisable = 1'b0, directMapEn = 1'b0, profStop = 1'b0;
  logic         reqValid = 1'b0;
  logic [25:0]  reqAddr = '0;
  logic         reqReady, respValid, fillReq;
  logic [31:0]  respData;
  logic [23:0]  fillAddr;
  logic         fillValid = 1'b0;
  logic [127:0] fillData = '0;
  logic [CNT_W-1:0] hitCount, missCount;

  int nChecks = 0, nFail = 0, fillCount = 0, gen = 0;
  int expHit = 0, expMiss = 0;
  bit done = 1'b0;
  logic [31:0] expData[$];
  string       expReq[$];

  always #2.5 clk = ~clk;

  flash_read_cache #(.HIT_W(HIT_W), .CNT_W(CNT_W)) i_flash_read_cache (
    .clk(clk), .rstN(rstN), .cacheDisable(cacheDisable),
    .directMapEn(directMapEn), .profStop(profStop), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqReady(reqReady), .respValid(respValid),
    .respData(respData), .fillReq(fillReq), .fillAddr(fillAddr),
    .fillValid(fillValid), .fillData(fillData), .hitCount(hitCount),
    .missCount(missCount)
  );

  function automatic logic [31:0] fw(input logic [23:0] a, input int g);
    return {8'(g), a} ^ 32'h3C00_0000;
  endfunction

  function automatic logic [25:0] cA(input int off);
    return 26'h0200000 + 26'(off);
  endfunction

  function automatic int so(input int tag, input int set);
    return (tag << 11) | (set << 4);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Flash model: answers each fill request after a short delay.
  initial forever begin
    @(negedge clk);
    fillValid = 1'b0;
    if (rstN && fillReq) begin
      repeat (2) @(negedge clk);
      for (int j = 0; j < 4; j++) fillData[32*j +: 32] = fw(fillAddr + 24'(4*j), gen);
      fillValid = 1'b1;
      fillCount++;
      @(negedge clk);
      fillValid = 1'b0;
    end
  end

  // Monitor: pops the scoreboard on each response.
  initial forever begin
    @(negedge clk);
    if (rstN && respValid) begin
      if (expData.size() == 0) begin
        chk(1'b0, "R2", "unexpected response", respData, 0);
      end else begin
        automatic logic [31:0] e = expData.pop_front();
        automatic string r = expReq.pop_front();
        chk(respData == e, r, "read data", respData, e);
      end
    end
  end

  task automatic rd(input logic [25:0] a, input bit expFill, input int g, input string req);
    logic [23:0] off;
    bit cach;
    int f0, cyc;
    cach = (a >= 26'h0200000) && (a < 26'h1200000);
    if (cach) off = 24'(a - 26'h0200000);
    else if (a >= 26'h1200000 && a < 26'h2200000) off = 24'(a - 26'h1200000);
    else off = a[23:0];
    expData.push_back(fw({off[23:2], 2'b00}, g));
    expReq.push_back(req);
    if (cach && !cacheDisable && !profStop) begin
      if (expFill) expMiss = (expMiss < 15) ? expMiss + 1 : 15;
      else         expHit  = (expHit  < 15) ? expHit  + 1 : 15;
    end
    @(negedge clk);
    reqAddr  = a;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    f0 = fillCount;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 1;
    while (!respValid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(fillCount - f0 == (expFill ? 1 : 0), req, "fill count", fillCount - f0, expFill);
    if (!expFill) chk(cyc == 2, req, "hit latency", cyc, 2);
    @(negedge clk);
  endtask

  task automatic profChk(input string req);
    chk(hitCount == CNT_W'(expHit), req, "hitCount", hitCount, expHit);
    chk(missCount == CNT_W'(expMiss), req, "missCount", missCount, expMiss);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(reqReady == 1'b1, "R1", "reqReady in reset", reqReady, 1);
    chk(respValid == 1'b0 && fillReq == 1'b0, "R1", "resp/fill in reset", {respValid, fillReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    chk(hitCount == 0 && missCount == 0, "R1", "counters after reset", {hitCount, missCount}, 0);

    // R2 miss then R3 hits on the same line
    rd(cA('h104), 1'b1, 0, "R2");
    rd(cA('h108), 1'b0, 0, "R3");
    rd(cA('h10C), 1'b0, 0, "R3");
    profChk("R11");

    // R11: frozen counters
    profStop = 1'b1;
    rd(cA('h100), 1'b0, 0, "R11");
    rd(cA('h200), 1'b1, 0, "R11");
    profChk("R11");
    profStop = 1'b0;

    // R5: disabled path sees changed flash, cached line survives
    gen = 1;
    cacheDisable = 1'b1;
    rd(cA('h104), 1'b1, 1, "R5");
    rd(cA('h104), 1'b1, 1, "R5");
    cacheDisable = 1'b0;
    rd(cA('h104), 1'b0, 0, "R5");

    // R4: alias and out-of-window reads fetch fresh data, no allocation
    rd(26'h1200104, 1'b1, 1, "R4");
    rd(26'h0000108, 1'b1, 1, "R4");
    rd(26'h1200104, 1'b1, 1, "R4");
    rd(cA('h104), 1'b0, 0, "R4");
    profChk("R11");

    // R6 and R8: four tags share set 5; equal counts tie
    for (int t = 1; t <= 4; t++) rd(cA(so(t, 5)), 1'b1, 1, "R6");
    for (int t = 1; t <= 4; t++) rd(cA(so(t, 5)), 1'b0, 1, "R6");
    rd(cA(so(5, 5)), 1'b1, 1, "R8");   // evicts tag 1 (way 3)
    rd(cA(so(2, 5)), 1'b0, 1, "R8");
    rd(cA(so(1, 5)), 1'b1, 1, "R8");

    // R7: least used way replaced (set 6, tag 4 hit least)
    for (int t = 1; t <= 4; t++) rd(cA(so(t, 6)), 1'b1, 1, "R7");
    for (int t = 1; t <= 3; t++) rd(cA(so(t, 6)), 1'b0, 1, "R7");
    rd(cA(so(5, 6)), 1'b1, 1, "R7");
    rd(cA(so(1, 6)), 1'b0, 1, "R7");
    rd(cA(so(4, 6)), 1'b1, 1, "R7");

    // R7: use count saturates (HIT_W = 2) rather than wrapping
    for (int t = 1; t <= 4; t++) rd(cA(so(t, 7)), 1'b1, 1, "R7");
    for (int k = 0; k < 4; k++) rd(cA(so(1, 7)), 1'b0, 1, "R7");
    for (int t = 2; t <= 4; t++) rd(cA(so(t, 7)), 1'b0, 1, "R7");
    rd(cA(so(5, 7)), 1'b1, 1, "R7");   // evicts tag 2 (count 2, way 2)
    rd(cA(so(1, 7)), 1'b0, 1, "R7");
    rd(cA(so(2, 7)), 1'b1, 1, "R7");

    // R10 and R9: switch to direct mapped
    directMapEn = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b0, "R10", "reqReady during invalidation", reqReady, 0);
    rd(cA('h100), 1'b1, 1, "R10");
    rd(cA('h2100), 1'b1, 1, "R9");
    rd(cA('h100), 1'b1, 1, "R9");
    rd(cA('h900), 1'b1, 1, "R9");
    rd(cA('h100), 1'b0, 1, "R9");

    // R10 and R6: back to 4-way, same pair now coexists
    directMapEn = 1'b0;
    @(negedge clk);
    chk(reqReady == 1'b0, "R10", "reqReady during invalidation", reqReady, 0);
    rd(cA('h100), 1'b1, 1, "R10");
    rd(cA('h2100), 1'b1, 1, "R6");
    rd(cA('h100), 1'b0, 1, "R6");

    // R12: counters have reached full scale and stay there
    profChk("R12");
    chk(expData.size() == 0, "R2", "responses outstanding", expData.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule